// File: doc/BRIEF.md
# Reset and Over-Temperature Pin Controller

This block drives two open-drain pins of a hardware-monitor device. The first pin is shared. It can serve as a timed master-reset line for the board, or as an over-temperature alarm. The second pin is a general-purpose output whose level software sets directly. Both outputs are modelled as pull-down enables: a 1 on a `*_pull_o` port means the pin is driven low, and a 0 means it is released.

Software uses a small register interface to pick the role of the shared pin. A self-clearing bit starts a reset pulse whose length is fixed in wall-clock time. The length is derived from the clock frequency and rounded up, so it is never shorter than the programmed time. In alarm mode the pin either follows a hysteresis comparator or latches each alternating threshold crossing until the status register is read.

Two inputs report the temperature comparisons:
- one is high while the temperature is above the upper limit;
- the other is high while it is below the hysteresis limit.

Top module: `ot_rst_pin_ctrl`

## Requirements
- R1: After reset, both pull outputs are 0. The registers read: control (address 0) = 0x40, pin select (address 1) = 0x00, alarm config (address 2) = 0x00, status (address 3) = 0x00.
- R2: Pin select bit 7 = 1 gives the shared pin the reset role, whatever bit 6 holds. Bit 7 = 0 with bit 6 = 1 gives it the alarm role. With both bits 0 the pin stays released whatever the temperature inputs do.
- R3: Writing control bit 4 = 1 starts a pulse of N = ceil(CLK_HZ*PULSE_US/1e6) clock cycles. In the reset role the shared pin pulls low from the cycle after the write for exactly N cycles.
- R4: Control bit 4 reads 1 while a pulse runs and 0 after it ends. Writing bit 4 = 1 during a pulse restarts the full N-cycle count. Writing bit 4 = 0 during a pulse does not shorten it.
- R5: In comparator mode (alarm config bit 2 = 0, alarm role), the pin pulls from the cycle after `temp_hi_i` is sampled high. It releases from the cycle after `temp_lo_i` is sampled high while `temp_hi_i` is low. Otherwise it holds its state.
- R6: In one-time mode (alarm config bit 2 = 1, alarm role), crossing events alternate. The first event after reset is `temp_hi_i` high, the next is `temp_lo_i` high, and so on. Each event latches the pin low. Inputs of the kind not currently awaited are ignored.
- R7: Reading address 3 returns the event latch in bit 0 and the comparator state in bit 1, then clears the latch. An event in the same cycle as the read keeps the latch set.
- R8: The general-purpose output pulls low exactly when control bit 6 = 0. The change shows in the cycle after the write.
- R9: Addresses 0 to 2 read back the last written value, except control bit 4 (see R4). Read data appears the cycle after `rd_en_i`. Other addresses read 0.
- R10: A pulse started while the pin is not in the reset role never pulls the pin. Bit 4 still clears itself after N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| temp_hi_i | input | 1 | Temperature above upper limit |
| temp_lo_i | input | 1 | Temperature below hysteresis limit |
| rstos_pull_o | output | 1 | Shared pin pull-down enable |
| gpo_pull_o | output | 1 | General-purpose pin pull-down enable |

## Verification
The one-time alarm state is the hardest case to reach from the ports. It is a latch plus an awaited-direction flag that keeps running through every earlier phase, so a status read that coincides with a crossing of the awaited kind depends on the whole input history. The stimulus runs long stretches of random threshold inputs and random status reads through a bench-side model that has tracked the tracker since reset. It then uses that model to build directed cycles: one with an ignored opposite-kind input, and one where the awaited crossing lands on the same cycle as the clearing read. Pulse restarts and cancel attempts are timed from the moment each write is taken.

// File: rtl/otr_pkg.sv
package otr_pkg;
   // register addresses
   localparam int unsigned ADR_CFG  = 0;
   localparam int unsigned ADR_SEL  = 1;
   localparam int unsigned ADR_OTC  = 2;
   localparam int unsigned ADR_STAT = 3;

   // field positions decoded by neighbouring logic
   localparam int unsigned CFG_PULSE_BIT = 4;
   localparam int unsigned CFG_GPO_BIT   = 6;
   localparam int unsigned SEL_RST_BIT   = 7;
   localparam int unsigned SEL_OT_BIT    = 6;
   localparam int unsigned OTC_MODE_BIT  = 2;
   localparam int unsigned STAT_LATCH_BIT = 0;
   localparam int unsigned STAT_CMP_BIT   = 1;

   localparam logic [7:0] CFG_RESET_VAL = 8'h40;

   typedef enum logic [1:0] {
      PIN_OFF      = 2'd0,
      PIN_RESET    = 2'd1,
      PIN_OVERTEMP = 2'd2
   } pin_role_e;

   typedef enum logic {
      OT_COMPARE = 1'b0,
      OT_ONESHOT = 1'b1
   } ot_mode_e;

   // cycles for a pulse of 'us' microseconds at 'hz', rounded up
   function automatic longint unsigned pulse_cycles(longint unsigned hz,
                                                    longint unsigned us);
      return (hz * us + 64'd999_999) / 64'd1_000_000;
   endfunction
endpackage

// File: rtl/otr_regs.sv
module otr_regs
   import otr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              busy_i,
   input  logic              latch_i,
   input  logic              cmp_i,
   output logic              start_o,
   output logic              stat_rd_o,
   output pin_role_e         role_o,
   output ot_mode_e          ot_mode_o,
   output logic              gpo_level_o
);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(ADR_CFG);
   localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(ADR_SEL);
   localparam logic [ADDR_W-1:0] A_OTC  = ADDR_W'(ADR_OTC);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);

   initial begin : elab_chk
      if (DATA_W < 8) $fatal(1, "otr_regs: DATA_W must be at least 8");
      if (ADDR_W < 2) $fatal(1, "otr_regs: ADDR_W must be at least 2");
   end

   logic [DATA_W-1:0] cfg_q, sel_q, otc_q;
   logic [DATA_W-1:0] rd_mux;

   assign start_o   = wr_en_i && (addr_i == A_CFG) && wdata_i[CFG_PULSE_BIT];
   assign stat_rd_o = rd_en_i && (addr_i == A_STAT);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cfg_q   <= DATA_W'(CFG_RESET_VAL);
         sel_q   <= '0;
         otc_q   <= '0;
         rdata_o <= '0;
      end else begin
         if (wr_en_i) begin
            case (addr_i)
               A_CFG: begin
                  cfg_q                <= wdata_i;
                  cfg_q[CFG_PULSE_BIT] <= 1'b0;   // held by the timer instead
               end
               A_SEL:   sel_q <= wdata_i;
               A_OTC:   otc_q <= wdata_i;
               default: ;
            endcase
         end
         if (rd_en_i) rdata_o <= rd_mux;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (addr_i)
         A_CFG: begin
            rd_mux                = cfg_q;
            rd_mux[CFG_PULSE_BIT] = busy_i;
         end
         A_SEL:  rd_mux = sel_q;
         A_OTC:  rd_mux = otc_q;
         A_STAT: begin
            rd_mux[STAT_LATCH_BIT] = latch_i;
            rd_mux[STAT_CMP_BIT]   = cmp_i;
         end
         default: rd_mux = '0;
      endcase
   end

   always_comb begin
      if (sel_q[SEL_RST_BIT])     role_o = PIN_RESET;
      else if (sel_q[SEL_OT_BIT]) role_o = PIN_OVERTEMP;
      else                        role_o = PIN_OFF;
   end

   assign ot_mode_o   = otc_q[OTC_MODE_BIT] ? OT_ONESHOT : OT_COMPARE;
   assign gpo_level_o = cfg_q[CFG_GPO_BIT];

   // R9: a write to the pin-select register is visible on the next cycle
   p_sel_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_SEL) |=> (sel_q == $past(wdata_i)));
   // R4: the stored copy of the pulse bit never holds a 1
   p_pulse_bit_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_CFG) |=> !cfg_q[CFG_PULSE_BIT]);
endmodule

// File: rtl/otr_pulse_timer.sv
module otr_pulse_timer
   import otr_pkg::*;
#(
   parameter int unsigned CLK_HZ   = 250_000_000,
   parameter int unsigned PULSE_US = 10_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o
);
   localparam longint unsigned LEN   = pulse_cycles(CLK_HZ, PULSE_US);
   localparam int unsigned     CNT_W = $clog2(LEN + 1);

   initial begin : elab_chk
      if (LEN < 1)        $fatal(1, "otr_pulse_timer: pulse rounds to zero cycles");
      if (LEN > 64'hFFFF_FFFF) $fatal(1, "otr_pulse_timer: pulse count too large");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (start_i)        cnt_q <= CNT_W'(LEN);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign busy_o = (cnt_q != '0);

   // R4: a start, including one during a pulse, reloads the full length
   p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (cnt_q == CNT_W'(LEN)));
   // R3: a running pulse advances by exactly one per cycle
   p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !start_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
   // R3: once idle the pulse stays idle until started
   p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/otr_temp_track.sv
module otr_temp_track (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic temp_hi_i,
   input  logic temp_lo_i,
   input  logic clr_i,
   output logic cmp_o,
   output logic latch_o
);
   logic want_low_q;   // 1: the next awaited event is a fall below hysteresis
   logic event_w;

   assign event_w = want_low_q ? temp_lo_i : temp_hi_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cmp_o      <= 1'b0;
         latch_o    <= 1'b0;
         want_low_q <= 1'b0;
      end else begin
         if (temp_hi_i)      cmp_o <= 1'b1;
         else if (temp_lo_i) cmp_o <= 1'b0;

         if (event_w) begin
            latch_o    <= 1'b1;
            want_low_q <= ~want_low_q;
         end else if (clr_i) begin
            latch_o    <= 1'b0;
         end
      end
   end

   // R5: a high sample sets the comparator
   p_cmp_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      temp_hi_i |=> cmp_o);
   // R5: a low sample without a high one releases it
   p_cmp_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!temp_hi_i && temp_lo_i) |=> !cmp_o);
   // R6: a rising crossing while awaited flips the awaited direction
   p_alternate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!want_low_q && temp_hi_i) |=> (want_low_q && latch_o));
   // R6: an opposite-kind input leaves the awaited direction alone
   p_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!want_low_q && !temp_hi_i) |=> !want_low_q);
   // R7: the latch holds until a status read
   p_latch_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch_o && !clr_i) |=> latch_o);
endmodule

// File: rtl/ot_rst_pin_ctrl.sv
module ot_rst_pin_ctrl
   import otr_pkg::*;
#(
   parameter int unsigned CLK_HZ   = 250_000_000,
   parameter int unsigned PULSE_US = 10_000,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 2,
   parameter bit          OUT_REG  = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              temp_hi_i,
   input  logic              temp_lo_i,
   output logic              rstos_pull_o,
   output logic              gpo_pull_o
);
   logic      busy, start, stat_rd, cmp, latch, gpo_level;
   pin_role_e role;
   ot_mode_e  ot_mode;
   logic      rstos_d, gpo_d;

   otr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i),
      .rd_en_i     (rd_en_i),
      .addr_i      (addr_i),
      .wdata_i     (wdata_i),
      .rdata_o     (rdata_o),
      .busy_i      (busy),
      .latch_i     (latch),
      .cmp_i       (cmp),
      .start_o     (start),
      .stat_rd_o   (stat_rd),
      .role_o      (role),
      .ot_mode_o   (ot_mode),
      .gpo_level_o (gpo_level)
   );

   otr_pulse_timer #(.CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .busy_o  (busy)
   );

   otr_temp_track u_track (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .temp_hi_i (temp_hi_i),
      .temp_lo_i (temp_lo_i),
      .clr_i     (stat_rd),
      .cmp_o     (cmp),
      .latch_o   (latch)
   );

   always_comb begin
      unique case (role)
         PIN_RESET:    rstos_d = busy;
         PIN_OVERTEMP: rstos_d = (ot_mode == OT_ONESHOT) ? latch : cmp;
         default:      rstos_d = 1'b0;
      endcase
   end

   assign gpo_d = ~gpo_level;

   generate
      if (OUT_REG) begin : g_out_flop
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               rstos_pull_o <= 1'b0;
               gpo_pull_o   <= 1'b0;
            end else begin
               rstos_pull_o <= rstos_d;
               gpo_pull_o   <= gpo_d;
            end
         end
      end else begin : g_out_comb
         assign rstos_pull_o = rstos_d;
         assign gpo_pull_o   = gpo_d;

         // R8: the general-purpose pin follows the written level bit
         p_gpo_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && addr_i == ADDR_W'(ADR_CFG))
               |=> (gpo_pull_o == !$past(wdata_i[CFG_GPO_BIT])));
         // R2: with no role selected the shared pin never pulls
         p_released_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (role == PIN_OFF) |-> !rstos_pull_o);
         // R10: outside the reset role a pulse cannot reach the pin
         p_pulse_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (busy && role == PIN_OFF) |-> !rstos_pull_o);
      end
   endgenerate
endmodule

// File: tb/ot_rst_pin_ctrl_tb.sv
`timescale 1ns/1ps
module ot_rst_pin_ctrl_tb;
   localparam int PER      = 4;
   localparam int CLK_HZ   = 100_050;
   localparam int PULSE_US = 10_000;

   function automatic int exp_len(longint hz, longint us);
      longint p;
      int n;
      p = hz * us;
      n = int'(p / 1_000_000);
      if (p % 1_000_000 != 0) n++;
      return n;
   endfunction

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       temp_hi = 1'b0, temp_lo = 1'b0;
   logic       rstos_pull, gpo_pull;

   int nchk = 0, nfail = 0;
   bit done = 0;
   logic [7:0] b_sel = 8'h00, b_otc = 8'h00;

   // independent model of the alarm tracker
   bit m_cmp, m_latch, m_want_low;
   logic [1:0] m_rd;

   always #(PER/2) clk = ~clk;

   ot_rst_pin_ctrl #(.CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
      .temp_hi_i(temp_hi), .temp_lo_i(temp_lo),
      .rstos_pull_o(rstos_pull), .gpo_pull_o(gpo_pull));

   always @(posedge clk) begin
      bit ev, rd;
      if (!rst_n) begin
         m_cmp = 0; m_latch = 0; m_want_low = 0; m_rd = '0;
      end else begin
         rd = rd_en && (addr == 2'd3);
         if (rd) m_rd = {m_cmp, m_latch};
         ev = m_want_low ? temp_lo : temp_hi;
         if (temp_hi)      m_cmp = 1;
         else if (temp_lo) m_cmp = 0;
         if (ev) begin
            m_latch = 1; m_want_low = !m_want_low;
         end else if (rd) m_latch = 0;
      end
   end

   function automatic bit exp_pin();
      if (b_sel[7])      return 1'b0;   // reset role: not used by the model
      else if (b_sel[6]) return b_otc[2] ? m_latch : m_cmp;
      else               return 1'b0;
   endfunction

   task automatic check(string req, longint act, longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // tasks start and end at a falling edge
   task automatic wr(logic [1:0] a, logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      if (a == 2'd1) b_sel = d;
      if (a == 2'd2) b_otc = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic wait_release(longint t0, output int len);
      int guard = 0;
      while (rstos_pull && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      len = int'(($time - t0) / PER);
   endtask

   initial begin : watchdog
      #(PER * 190_000);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      int len, plen;
      longint t0;
      bit seen;
      plen = exp_len(CLK_HZ, PULSE_US);
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 shared pull", rstos_pull, 0);
      check("R1 gpo pull", gpo_pull, 0);
      rd(2'd0, d); check("R1 cfg", d, 8'h40);
      rd(2'd1, d); check("R1 sel", d, 8'h00);
      rd(2'd2, d); check("R1 otc", d, 8'h00);
      rd(2'd3, d); check("R1 status", d, 8'h00);

      // R9 readback, R8 gpo
      wr(2'd1, 8'h35); rd(2'd1, d); check("R9 sel readback", d, 8'h35);
      wr(2'd2, 8'hA3); rd(2'd2, d); check("R9 otc readback", d, 8'hA3);
      wr(2'd0, 8'hA7); check("R8 gpo pulled", gpo_pull, 1);
      rd(2'd0, d); check("R9 cfg readback", d, 8'hA7);
      wr(2'd0, 8'h40); check("R8 gpo released", gpo_pull, 0);

      // R2 released with no role despite a hot input
      temp_hi = 1'b1;
      repeat (4) @(negedge clk);
      check("R2 no role released", rstos_pull, 0);
      temp_hi = 1'b0;
      @(negedge clk);

      // R3 pulse length in reset role
      check("R3 length constant", plen, 1001);
      wr(2'd1, 8'h80);
      wr(2'd0, 8'h50); t0 = $time;
      check("R3 pull starts", rstos_pull, 1);
      wait_release(t0, len);
      check("R3 pulse length", len, plen);
      rd(2'd0, d); check("R4 bit clears after pulse", d[4], 0);

      // R4 readback during pulse, restart
      wr(2'd0, 8'h50);
      repeat (200) @(negedge clk);
      rd(2'd0, d); check("R4 bit reads busy", d[4], 1);
      wr(2'd0, 8'h50); t0 = $time;
      wait_release(t0, len);
      check("R4 restart length", len, plen);

      // R4 writing zero does not shorten the pulse; R2 both bits gives reset role
      wr(2'd1, 8'hC0);
      wr(2'd0, 8'h50); t0 = $time;
      repeat (100) @(negedge clk);
      wr(2'd0, 8'h40);
      check("R2 both bits reset role", rstos_pull, 1);
      wait_release(t0, len);
      check("R4 zero write no cancel", len, plen);

      // R10 pulse outside reset role
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h50);
      seen = 0;
      for (int i = 0; i < plen + 50; i++) begin
         if (rstos_pull) seen = 1;
         @(negedge clk);
      end
      check("R10 pin untouched", seen, 0);
      rd(2'd0, d); check("R10 bit self-clears", d[4], 0);

      // R5 comparator directed
      wr(2'd2, 8'h00); wr(2'd1, 8'h40);
      temp_lo = 1'b1; @(negedge clk); temp_lo = 1'b0;
      check("R5 low start", rstos_pull, 0);
      temp_hi = 1'b1; @(negedge clk); temp_hi = 1'b0;
      check("R5 set on high", rstos_pull, 1);
      repeat (5) @(negedge clk);
      check("R5 hold between limits", rstos_pull, 1);
      temp_lo = 1'b1; @(negedge clk); temp_lo = 1'b0;
      check("R5 release on low", rstos_pull, 0);

      // R5 random comparator
      for (int i = 0; i < 3000; i++) begin
         bit r;
         temp_hi = ($urandom % 8) == 0;
         temp_lo = ($urandom % 6) == 0;
         r = ($urandom % 10) == 0;
         rd_en = r; addr = 2'd3;
         @(negedge clk);
         check("R5 comparator pin", rstos_pull, exp_pin());
         if (r) check("R7 status read", rdata[1:0], m_rd);
      end
      rd_en = 1'b0; temp_hi = 1'b0; temp_lo = 1'b0;

      // R6/R7 random one-time mode
      wr(2'd2, 8'h04);
      for (int i = 0; i < 3000; i++) begin
         bit r;
         temp_hi = ($urandom % 8) == 0;
         temp_lo = ($urandom % 6) == 0;
         r = ($urandom % 10) == 0;
         rd_en = r; addr = 2'd3;
         @(negedge clk);
         check("R6 one-time pin", rstos_pull, exp_pin());
         if (r) check("R7 status read", rdata[1:0], m_rd);
      end
      rd_en = 1'b0; temp_hi = 1'b0; temp_lo = 1'b0;

      // R6 ignored opposite input, R7 clear and same-cycle event
      rd(2'd3, d);
      check("R7 cleared by read", rstos_pull, 0);
      if (m_want_low) temp_hi = 1'b1; else temp_lo = 1'b1;
      @(negedge clk);
      temp_hi = 1'b0; temp_lo = 1'b0;
      check("R6 opposite kind ignored", rstos_pull, 0);
      if (m_want_low) temp_lo = 1'b1; else temp_hi = 1'b1;
      rd_en = 1'b1; addr = 2'd3;
      @(negedge clk);
      rd_en = 1'b0; temp_hi = 1'b0; temp_lo = 1'b0;
      check("R7 event beats read", rstos_pull, 1);
      check("R7 read saw clear latch", rdata[0], 0);
      rd(2'd3, d); check("R7 latch reported", d[0], 1);
      check("R7 latch cleared", rstos_pull, 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule